// File: doc/BRIEF.md
# Pseudo-static RAM access and refresh controller

This block connects a synchronous single-byte request port to an asynchronous pseudo-static RAM that has an SRAM-style pinout. The memory takes a full flat address, eight data lines, a chip enable, a write enable, and one pin that serves two purposes. When the chip enable is active, that pin is the read output enable. When the chip enable is inactive, it is the refresh strobe. The controller turns each accepted host read or write into one chip-enable cycle whose timing is correct. Between these cycles it issues short auto-refresh pulses at a fixed cadence. On request it parks the memory in self-refresh and later brings it back out.

All timing limits are parameters given in nanoseconds, together with the clock period. Every minimum is rounded up to whole clock cycles. Elaboration stops if a maximum limit, such as the longest allowed chip-enable pulse or the longest auto-refresh pulse, cannot be met. Host requests use a valid/ready handshake. Read data comes back on a one-cycle response strobe.

Top module: `psram_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, chip enable, write enable and the shared enable/refresh pin are all inactive (high). `rsp_valid` and `sleep_ack` are low, and `req_ready` is high.
- R2: Each access holds chip enable low for exactly CE_CYC consecutive cycles. CE_CYC is the larger of ceil(T_CE_MIN_NS/CLK_NS) and ceil(T_RC_NS/CLK_NS) − PRE_CYC. The CE_CYC·CLK_NS product never exceeds T_CE_MAX_NS.
- R3: Chip enable stays high for at least PRE_CYC cycles between two accesses. PRE_CYC is the larger of ceil(T_PRE_NS/CLK_NS) and ceil(T_RFD_NS/CLK_NS).
- R4: A write holds write enable low for the first CE_CYC−1 cycles of its chip-enable pulse. Write enable rises one cycle before chip enable. Write data is driven onto the bus only while write enable is low.
- R5: A read holds the enable/refresh pin low for its whole chip-enable pulse and keeps write enable high. The bus is sampled in the next-to-last low cycle. `rsp_valid` pulses for one cycle, in the first cycle in which chip enable is high again.
- R6: An auto-refresh drives the enable/refresh pin low for exactly FAP_CYC = ceil(T_FAP_MIN_NS/CLK_NS) cycles while chip enable is high. It starts only after chip enable has been high for at least PRE_CYC cycles. It is followed by at least RHI_CYC cycles with the pin high before any chip enable or further refresh. RHI_CYC is the larger of ceil(T_FP_NS/CLK_NS) and ceil(T_FC_NS/CLK_NS) − FAP_CYC.
- R7: Outside self-refresh, two successive refresh-pin falls with chip enable high are never more than floor(T_REFI_NS/CLK_NS) cycles apart. This also holds under continuous host traffic.
- R8: A due refresh takes precedence over a host request. `req_ready` is low whenever a refresh is due or a refresh pulse is in progress.
- R9: While `sleep_req` is held, the enable/refresh pin stays low and chip enable stays high. `sleep_ack` rises in the SELF_CYC-th low cycle. SELF_CYC is the larger of ceil(T_SELF_NS/CLK_NS) and floor(T_FAP_MAX_NS/CLK_NS)+1. After `sleep_req` is released, the pin rises and stays high for at least FRS_CYC = ceil(T_FRS_NS/CLK_NS) cycles before the next chip enable.
- R10: Data written before a self-refresh entry and exit, and before any number of auto-refresh pulses, reads back unchanged.
- R11: Write enable and the enable/refresh pin are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid |
| sleep_req | input | 1 | Level request for self-refresh |
| sleep_ack | output | 1 | Memory is held in self-refresh |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq | inout | DATA_W | Bidirectional memory data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_rfsh_n | output | 1 | Read enable / refresh strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The bench builds the controller with ADDR_W = 6, a 4 ns clock and the default access timings, which gives CE_CYC = 30, PRE_CYC = 18, FAP_CYC = 20 and RHI_CYC = 28. It also shortens T_REFI_NS to 1000, T_FAP_MAX_NS to 1000 and T_SELF_NS to 1200. A 64-word address space can then be swept exhaustively several times, and a refresh falls due every 250 cycles or less, so dozens of pulses collide with host traffic. The self-refresh minimum also drops to 300 cycles. A behavioural memory in the bench measures every strobe width and gap in cycles against values derived from the requirements, and it verifies contents across refresh and self-refresh.

// File: rtl/psram_pkg.sv
package psram_pkg;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [2:0] {
        S_IDLE,
        S_CE,
        S_PRE,
        S_RLOW,
        S_RHIGH,
        S_SLOW,
        S_SEXIT
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_rfsh_n;
        logic we_n;
    } strobe_t;

endpackage

// File: rtl/psram_refresh_timer.sv
module psram_refresh_timer #(
    parameter int PERIOD = 3856,
    parameter int CNT_W  = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic grant,
    input  logic hold,
    output logic pending
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;

    always_ff @(posedge clk) begin
        if (rst || grant || hold) begin
            cnt_q  <= RELOAD;
            pend_q <= 1'b0;
        end else if (cnt_q == '0) begin
            pend_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/psram_seq.sv
module psram_seq
    import psram_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int CE_CYC   = 30,
    parameter int PRE_CYC  = 18,
    parameter int FAP_CYC  = 20,
    parameter int RHI_CYC  = 28,
    parameter int SELF_CYC = 2001,
    parameter int FRS_CYC  = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_write,
    input  logic ref_pending,
    input  logic sleep_req,
    output logic req_ready,
    output logic load,
    output logic ref_grant,
    output logic self_hold,
    output logic drive,
    output logic capture,
    output logic respond,
    output logic sleep_ack,
    output logic mem_ce_n,
    output logic mem_oe_rfsh_n,
    output logic mem_we_n
);
    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wr_q;
    logic             cnt_zero;
    logic             idle_free;
    strobe_t          strb;

    function automatic logic [CNT_W-1:0] span(input int n);
        return CNT_W'(n - 1);
    endfunction

    assign cnt_zero  = (cnt_q == '0);
    assign idle_free = (state_q == S_IDLE) && !ref_pending && !sleep_req;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
        unique case (state_q)
            S_IDLE: begin
                if (ref_pending) begin
                    state_d = S_RLOW;
                    cnt_d   = span(FAP_CYC);
                end else if (sleep_req) begin
                    state_d = S_SLOW;
                    cnt_d   = span(SELF_CYC);
                end else if (req_valid) begin
                    state_d = S_CE;
                    cnt_d   = span(CE_CYC);
                end
            end
            S_CE: begin
                if (cnt_zero) begin
                    state_d = S_PRE;
                    cnt_d   = span(PRE_CYC);
                end
            end
            S_PRE:   if (cnt_zero) state_d = S_IDLE;
            S_RLOW: begin
                if (cnt_zero) begin
                    state_d = S_RHIGH;
                    cnt_d   = span(RHI_CYC);
                end
            end
            S_RHIGH: if (cnt_zero) state_d = S_IDLE;
            S_SLOW: begin
                if (cnt_zero && !sleep_req) begin
                    state_d = S_SEXIT;
                    cnt_d   = span(FRS_CYC);
                end
            end
            S_SEXIT: if (cnt_zero) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (load) wr_q <= req_write;
        end
    end

    always_comb begin
        strb.ce_n      = (state_q != S_CE);
        strb.oe_rfsh_n = !(((state_q == S_CE) && !wr_q) ||
                           (state_q == S_RLOW) || (state_q == S_SLOW));
        strb.we_n      = !((state_q == S_CE) && wr_q && !cnt_zero);
    end

    assign mem_ce_n      = strb.ce_n;
    assign mem_oe_rfsh_n = strb.oe_rfsh_n;
    assign mem_we_n      = strb.we_n;

    assign req_ready = idle_free;
    assign load      = idle_free && req_valid;
    assign ref_grant = (state_q == S_IDLE) && ref_pending;
    assign self_hold = (state_q == S_SLOW);
    assign drive     = !strb.we_n;
    assign capture   = (state_q == S_CE) && !wr_q && (cnt_q == CNT_W'(1));
    assign respond   = (state_q == S_CE) && !wr_q && cnt_zero;
    assign sleep_ack = (state_q == S_SLOW) && cnt_zero;
endmodule

// File: rtl/psram_dq.sv
module psram_dq #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_wdata,
    input  logic              drive,
    input  logic              capture,
    input  logic              respond,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            if (load) begin
                addr_q  <= ld_addr;
                wdata_q <= ld_wdata;
            end
            if (capture) rdata_q <= mem_dq;
            rsp_q <= respond;
        end
    end

    assign mem_dq    = drive ? wdata_q : {DATA_W{1'bz}};
    assign mem_addr  = addr_q;
    assign rsp_valid = rsp_q;
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_NS        = 4,
    parameter int T_RC_NS       = 190,
    parameter int T_CE_MIN_NS   = 120,
    parameter int T_CE_MAX_NS   = 10000,
    parameter int T_PRE_NS      = 70,
    parameter int T_RFD_NS      = 70,
    parameter int T_FAP_MIN_NS  = 80,
    parameter int T_FAP_MAX_NS  = 8000,
    parameter int T_FP_NS       = 30,
    parameter int T_FC_NS       = 190,
    parameter int T_SELF_NS     = 8000,
    parameter int T_FRS_NS      = 600,
    parameter int T_REFI_NS     = 15625
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              sleep_req,
    output logic              sleep_ack,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              mem_ce_n,
    output logic              mem_oe_rfsh_n,
    output logic              mem_we_n
);
    localparam int PRE_CYC    = imax(cdiv(T_PRE_NS, CLK_NS), cdiv(T_RFD_NS, CLK_NS));
    localparam int CE_CYC     = imax(cdiv(T_CE_MIN_NS, CLK_NS), cdiv(T_RC_NS, CLK_NS) - PRE_CYC);
    localparam int FAP_CYC    = cdiv(T_FAP_MIN_NS, CLK_NS);
    localparam int RHI_CYC    = imax(cdiv(T_FP_NS, CLK_NS), cdiv(T_FC_NS, CLK_NS) - FAP_CYC);
    localparam int SELF_CYC   = imax(cdiv(T_SELF_NS, CLK_NS), T_FAP_MAX_NS / CLK_NS + 1);
    localparam int FRS_CYC    = cdiv(T_FRS_NS, CLK_NS);
    localparam int REFI_CYC   = T_REFI_NS / CLK_NS;
    localparam int REF_PERIOD = REFI_CYC - CE_CYC - PRE_CYC - 2;
    localparam int MAX_SPAN   = imax(imax(imax(CE_CYC, PRE_CYC), imax(FAP_CYC, RHI_CYC)),
                                     imax(imax(SELF_CYC, FRS_CYC), REF_PERIOD));
    localparam int CNT_W      = $clog2(MAX_SPAN + 1);

    generate
        if (CE_CYC * CLK_NS > T_CE_MAX_NS) begin : g_bad_ce
            $error("chip-enable maximum width cannot be met");
        end
        if (FAP_CYC * CLK_NS > T_FAP_MAX_NS) begin : g_bad_fap
            $error("auto-refresh pulse maximum cannot be met");
        end
        if (REF_PERIOD < 1) begin : g_bad_refi
            $error("refresh interval shorter than one access");
        end
        if (CE_CYC < 2) begin : g_bad_short
            $error("chip-enable pulse needs at least two cycles");
        end
    endgenerate

    logic ref_pending;
    logic ref_grant;
    logic self_hold;
    logic load;
    logic drive;
    logic capture;
    logic respond;

    psram_refresh_timer #(
        .PERIOD (REF_PERIOD),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .grant   (ref_grant),
        .hold    (self_hold),
        .pending (ref_pending)
    );

    psram_seq #(
        .CNT_W    (CNT_W),
        .CE_CYC   (CE_CYC),
        .PRE_CYC  (PRE_CYC),
        .FAP_CYC  (FAP_CYC),
        .RHI_CYC  (RHI_CYC),
        .SELF_CYC (SELF_CYC),
        .FRS_CYC  (FRS_CYC)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .ref_pending   (ref_pending),
        .sleep_req     (sleep_req),
        .req_ready     (req_ready),
        .load          (load),
        .ref_grant     (ref_grant),
        .self_hold     (self_hold),
        .drive         (drive),
        .capture       (capture),
        .respond       (respond),
        .sleep_ack     (sleep_ack),
        .mem_ce_n      (mem_ce_n),
        .mem_oe_rfsh_n (mem_oe_rfsh_n),
        .mem_we_n      (mem_we_n)
    );

    psram_dq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dq (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .ld_addr   (req_addr),
        .ld_wdata  (req_wdata),
        .drive     (drive),
        .capture   (capture),
        .respond   (respond),
        .mem_addr  (mem_addr),
        .mem_dq    (mem_dq),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/psram_ctrl_checker.sv
module psram_ctrl_checker #(
    parameter int CE_CYC  = 30,
    parameter int PRE_CYC = 18
) (
    input logic clk,
    input logic rst,
    input logic mem_ce_n,
    input logic mem_oe_rfsh_n,
    input logic mem_we_n,
    input logic req_ready,
    input logic ref_pending,
    input logic rsp_valid,
    input logic sleep_ack
);
    localparam int W = $clog2(CE_CYC + PRE_CYC + 2);

    logic [W-1:0] lo_cnt;
    logic [W-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
            hi_cnt <= W'(PRE_CYC);
        end else begin
            lo_cnt <= mem_ce_n ? '0 : lo_cnt + 1'b1;
            if (!mem_ce_n)                hi_cnt <= '0;
            else if (hi_cnt != W'(PRE_CYC)) hi_cnt <= hi_cnt + 1'b1;
        end
    end

    p_ce_width_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ce_n) |-> (lo_cnt == W'(CE_CYC)));

    p_ce_bound_r2: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> (lo_cnt < W'(CE_CYC)));

    p_precharge_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> (hi_cnt >= W'(PRE_CYC)));

    p_we_in_ce_r4: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |=> !mem_ce_n);

    p_rsp_at_ce_rise_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $rose(mem_ce_n));

    p_refresh_ce_high_r6: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_rfsh_n && mem_ce_n) |-> !req_ready);

    p_ready_pending_r8: assert property (@(posedge clk) disable iff (rst)
        ref_pending |-> !req_ready);

    p_ack_strobes_r9: assert property (@(posedge clk) disable iff (rst)
        sleep_ack |-> (mem_ce_n && !mem_oe_rfsh_n && !req_ready));

    p_oe_we_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(!mem_we_n && !mem_oe_rfsh_n));
endmodule

bind psram_ctrl psram_ctrl_checker #(
    .CE_CYC  (CE_CYC),
    .PRE_CYC (PRE_CYC)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mem_ce_n      (mem_ce_n),
    .mem_oe_rfsh_n (mem_oe_rfsh_n),
    .mem_we_n      (mem_we_n),
    .req_ready     (req_ready),
    .ref_pending   (ref_pending),
    .rsp_valid     (rsp_valid),
    .sleep_ack     (sleep_ack)
);

// File: tb/psram_ctrl_bench.sv
module psram_ctrl_bench;
    localparam int AW       = 6;
    localparam int DEPTH    = 1 << AW;
    localparam int CLK      = 4;
    // expected cycle counts from the requirements at a 4 ns clock
    localparam int PRE_EXP  = ((70 + CLK - 1) / CLK);
    localparam int CE_EXP   = ((120 + CLK - 1) / CLK) > (((190 + CLK - 1) / CLK) - PRE_EXP)
                              ? ((120 + CLK - 1) / CLK) : (((190 + CLK - 1) / CLK) - PRE_EXP);
    localparam int FAP_EXP  = (80 + CLK - 1) / CLK;
    localparam int RHI_EXP  = ((190 + CLK - 1) / CLK) - FAP_EXP;
    localparam int SELF_EXP = (1200 + CLK - 1) / CLK;
    localparam int FRS_EXP  = (600 + CLK - 1) / CLK;
    localparam int REFI_EXP = 1000 / CLK;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_wdata = '0;
    logic          sleep_req = 1'b0;
    logic          req_ready, rsp_valid, sleep_ack;
    logic [7:0]    rsp_rdata;
    logic [AW-1:0] mem_addr;
    wire  [7:0]    mem_dq;
    logic          mem_ce_n, mem_oe_rfsh_n, mem_we_n;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    psram_ctrl #(
        .ADDR_W       (AW),
        .DATA_W       (8),
        .CLK_NS       (CLK),
        .T_FAP_MAX_NS (1000),
        .T_SELF_NS    (1200),
        .T_REFI_NS    (1000)
    ) u_psram_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .sleep_req     (sleep_req),
        .sleep_ack     (sleep_ack),
        .mem_addr      (mem_addr),
        .mem_dq        (mem_dq),
        .mem_ce_n      (mem_ce_n),
        .mem_oe_rfsh_n (mem_oe_rfsh_n),
        .mem_we_n      (mem_we_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural memory with cycle-level timing monitor
    logic [7:0] mem_q [DEPTH];
    assign mem_dq = (!mem_ce_n && !mem_oe_rfsh_n && mem_we_n) ? mem_q[mem_addr] : 8'bz;

    int ce_lo, ce_hi, rf_lo, since_ref, ref_gap, need_gap, we_lo;
    bit p_ce, p_rf, p_we, p_ack, ack_seen;

    initial begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] = 8'h00;
    end

    always @(negedge clk) begin
        if (rst) begin
            ce_lo = 0; ce_hi = 1000; rf_lo = 0; since_ref = 1000; ref_gap = 0;
            need_gap = 0; we_lo = 0; p_ce = 1; p_rf = 1; p_we = 1; p_ack = 0; ack_seen = 0;
        end else begin
            if (p_ce && !mem_ce_n) begin
                chk(ce_hi >= PRE_EXP, "R3 precharge", ce_hi, PRE_EXP);
                chk(since_ref >= need_gap, "R6/R9 gap after refresh", since_ref, need_gap);
            end
            if (!p_ce && mem_ce_n) chk(ce_lo == CE_EXP, "R2 ce width", ce_lo, CE_EXP);
            if (!p_we && mem_we_n) chk(we_lo == CE_EXP - 1, "R4 we width", we_lo, CE_EXP - 1);
            if (!mem_we_n && !mem_oe_rfsh_n) chk(1'b0, "R11 oe/we overlap", 1, 0);
            if (!mem_we_n && mem_ce_n) chk(1'b0, "R4 we outside ce", 1, 0);
            if (mem_ce_n && p_rf && !mem_oe_rfsh_n) begin
                chk(ce_hi >= PRE_EXP, "R6 delay from ce", ce_hi, PRE_EXP);
                chk(since_ref >= RHI_EXP, "R6 refresh spacing", since_ref, RHI_EXP);
                chk(ref_gap <= REFI_EXP, "R7 refresh interval", ref_gap, REFI_EXP);
                chk(!req_ready, "R8 ready during refresh", req_ready, 0);
                ref_gap = 0;
                ack_seen = 0;
            end
            if (mem_ce_n && !p_rf && mem_oe_rfsh_n && rf_lo > 0) begin
                if (ack_seen) begin
                    chk(rf_lo >= SELF_EXP, "R9 self width", rf_lo, SELF_EXP);
                    need_gap = FRS_EXP;
                    ref_gap = 0;
                end else begin
                    chk(rf_lo == FAP_EXP, "R6 auto width", rf_lo, FAP_EXP);
                    need_gap = RHI_EXP;
                end
                since_ref = 0;
            end
            if (sleep_ack && !p_ack) chk(rf_lo == SELF_EXP - 1, "R9 ack timing", rf_lo, SELF_EXP - 1);
            if (sleep_ack) ack_seen = 1;
            if (!mem_ce_n && !mem_we_n) mem_q[mem_addr] = mem_dq;

            ce_lo = mem_ce_n ? 0 : ce_lo + 1;
            ce_hi = mem_ce_n ? ce_hi + 1 : 0;
            rf_lo = (mem_ce_n && !mem_oe_rfsh_n) ? rf_lo + 1 : 0;
            we_lo = mem_we_n ? 0 : we_lo + 1;
            if (mem_oe_rfsh_n) since_ref = since_ref + 1;
            if (!(mem_ce_n && !mem_oe_rfsh_n)) ref_gap = ref_gap + 1;
            p_ce = mem_ce_n; p_rf = mem_oe_rfsh_n; p_we = mem_we_n; p_ack = sleep_ack;
        end
    end

    function automatic logic [7:0] pat(input int a, input int k);
        return 8'((a * 37 + 11 * k + 5) ^ (k * 8'h5A));
    endfunction

    task automatic do_req(input bit wr, input int a, input logic [7:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(a);
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_read(input int a, input logic [7:0] exp, input string tag);
        int guard;
        do_req(1'b0, a, 8'h00);
        guard = 0;
        while (!rsp_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(rsp_valid && rsp_rdata == exp, tag, int'(rsp_rdata), int'(exp));
        @(negedge clk);
        chk(!rsp_valid, "R5 response one cycle", rsp_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        bit held_ok;
        int wait_n;
        repeat (4) @(negedge clk);
        chk(mem_ce_n && mem_oe_rfsh_n && mem_we_n, "R1 strobes in reset",
            {mem_ce_n, mem_oe_rfsh_n, mem_we_n}, 7);
        chk(!rsp_valid && !sleep_ack, "R1 outputs in reset", {rsp_valid, sleep_ack}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_rfsh_n && mem_we_n, "R1 strobes after reset",
            {mem_ce_n, mem_oe_rfsh_n, mem_we_n}, 7);
        chk(req_ready, "R1 ready after reset", req_ready, 1);

        // exhaustive write sweep then read sweep across refresh pulses
        for (int a = 0; a < DEPTH; a++) do_req(1'b1, a, pat(a, 1));
        for (int a = 0; a < DEPTH; a++) do_read(a, pat(a, 1), "R5 read sweep");

        // interleaved write/read, descending addresses
        for (int a = DEPTH - 1; a >= 0; a--) begin
            do_req(1'b1, a, pat(a, 2));
            do_read(a, pat(a, 2), "R5 write-read pair");
        end

        // self-refresh entry, hold, exit
        sleep_req = 1'b1;
        wait_n = 0;
        while (!sleep_ack && wait_n < 2000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(sleep_ack, "R9 ack reached", sleep_ack, 1);
        held_ok = 1'b1;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (!(mem_ce_n && !mem_oe_rfsh_n && !req_ready && sleep_ack)) held_ok = 1'b0;
        end
        chk(held_ok, "R9 held in self-refresh", held_ok, 1);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = '0;
        sleep_req = 1'b0;
        @(negedge clk);
        chk(!sleep_ack && mem_oe_rfsh_n, "R9 exit strobes", {sleep_ack, mem_oe_rfsh_n}, 1);
        chk(!req_ready, "R9 no access during exit delay", req_ready, 0);
        req_valid = 1'b0;
        for (int a = 0; a < DEPTH; a++) do_read(a, pat(a, 2), "R10 data after self-refresh");

        repeat (300) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule